// File: doc/BRIEF.md
# Data Space Address Router

The router sits between a processor's load/store unit and the four places a data-space byte can live. It accepts a single load or store carrying a 16-bit byte address. It decides which target owns that address, rebases the address into the target's local index, and forwards the write strobe and data. For loads, it captures the returned byte into a register and presents it with a one-cycle valid pulse. The register file occupies the lowest 32 addresses. The 64 I/O registers follow them, then 1024 bytes of on-chip SRAM, and everything above that goes to an external memory bus.

A second requester port reaches the I/O registers directly through a 6-bit I/O number. I/O number k names the same register as data-space address k + 0x20. This port has priority over the data-space port. Register-file, I/O and SRAM accesses finish in the cycle they are accepted. An external access keeps the data-space port busy, with its address, write strobe and write data frozen, until the external ready input is seen high.

Top module: `dspace_router`

## Requirements
- R1: A data-space address in 0x0000..0x001F asserts only rf_req_o, with rf_addr_o equal to the address, and completes (ds_ready_o high) in the cycle it is presented.
- R2: A data-space address in 0x0020..0x005F asserts only iot_req_o, with iot_addr_o equal to the address minus 0x20, and completes in the cycle it is presented.
- R3: A data-space address in 0x0060..0x045F asserts only sram_req_o, with the 10-bit sram_addr_o equal to the address minus 0x60, and completes in the cycle it is presented.
- R4: A data-space address in 0x0460..0xFFFF asserts only ext_req_o, with ext_addr_o equal to the full 16-bit address.
- R5: A direct I/O request with number k asserts iot_req_o with iot_addr_o = k and io_ready_o in the same cycle. A read returns the same register data that a data-space read of k + 0x20 returns.
- R6: When io_req_i and ds_req_i are high in the same cycle while no external access is pending, the direct I/O request is served and ds_ready_o stays low. The data-space request is then served in the following cycle.
- R7: After an external access starts, ext_req_o, ext_addr_o, ext_we_o and ext_wdata_o stay unchanged until the cycle in which ext_ready_i is high. ds_ready_o is high in exactly that cycle, so an access with W low-ready cycles completes W cycles after it is presented.
- R8: While an external access is waiting for ext_ready_i, a direct I/O request is still served in the cycle it is presented.
- R9: One cycle after a completed read on either port, the port's rvalid output pulses high for one cycle with the read byte on its rdata output. A completed write produces no rvalid pulse.
- R10: During and straight after reset, no external request is pending and neither rvalid output is high.
- R11: For a store, the selected target receives a write strobe of 1 and the requester's write byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ds_req_i | input | 1 | Data-space request, held until ds_ready_o |
| ds_we_i | input | 1 | Data-space store (1) or load (0) |
| ds_addr_i | input | 16 | Data-space byte address |
| ds_wdata_i | input | 8 | Data-space store byte |
| ds_ready_o | output | 1 | Data-space request completes this cycle |
| ds_rdata_o | output | 8 | Registered data-space load byte |
| ds_rvalid_o | output | 1 | Load byte valid pulse |
| io_req_i | input | 1 | Direct I/O request |
| io_we_i | input | 1 | Direct I/O store (1) or load (0) |
| io_addr_i | input | 6 | I/O register number |
| io_wdata_i | input | 8 | Direct I/O store byte |
| io_ready_o | output | 1 | Direct I/O request completes this cycle |
| io_rdata_o | output | 8 | Registered direct I/O load byte |
| io_rvalid_o | output | 1 | Direct I/O load byte valid pulse |
| rf_req_o | output | 1 | Register-file access |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_addr_o | output | 5 | Register index |
| rf_wdata_o | output | 8 | Register write byte |
| rf_rdata_i | input | 8 | Register read byte, same cycle |
| iot_req_o | output | 1 | I/O register access |
| iot_we_o | output | 1 | I/O register write strobe |
| iot_addr_o | output | 6 | I/O register number |
| iot_wdata_o | output | 8 | I/O write byte |
| iot_rdata_i | input | 8 | I/O read byte, same cycle |
| sram_req_o | output | 1 | SRAM access |
| sram_we_o | output | 1 | SRAM write strobe |
| sram_addr_o | output | 10 | SRAM byte index |
| sram_wdata_o | output | 8 | SRAM write byte |
| sram_rdata_i | input | 8 | SRAM read byte, same cycle |
| ext_req_o | output | 1 | External bus access |
| ext_we_o | output | 1 | External write strobe |
| ext_addr_o | output | 16 | External byte address |
| ext_wdata_o | output | 8 | External write byte |
| ext_rdata_i | input | 8 | External read byte, valid with ext_ready_i |
| ext_ready_i | input | 1 | External access completes |

## Verification
The assertions assume that a requester holds ds_req_i together with its address, strobe and data steady until ds_ready_o is sampled high. They also assume that the internal targets return read data combinationally in the request cycle, and that ext_ready_i is only meaningful while ext_req_o is high. The bench drives each request from the falling edge and releases it only after it has seen ready. It keeps ext_ready_i low except inside an external access, and raises it after a chosen number of wait cycles. Its target models return bytes that are simple functions of the index they receive, so a wrong rebase shows up as wrong data.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    TGT_RF   = 2'd0,
    TGT_IO   = 2'd1,
    TGT_SRAM = 2'd2,
    TGT_EXT  = 2'd3
  } tgt_e;
endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RF_DEPTH   = 32,
  parameter int IO_DEPTH   = 64,
  parameter int SRAM_DEPTH = 1024
) (
  input  logic [ADDR_W-1:0]             addr_i,
  output tgt_e                          tgt_o,
  output logic [$clog2(RF_DEPTH)-1:0]   rf_idx_o,
  output logic [$clog2(IO_DEPTH)-1:0]   io_idx_o,
  output logic [$clog2(SRAM_DEPTH)-1:0] sram_idx_o
);
  localparam int RF_AW     = $clog2(RF_DEPTH);
  localparam int IO_AW     = $clog2(IO_DEPTH);
  localparam int SRAM_AW   = $clog2(SRAM_DEPTH);
  localparam int IO_BASE   = RF_DEPTH;
  localparam int SRAM_BASE = IO_BASE + IO_DEPTH;
  localparam int EXT_BASE  = SRAM_BASE + SRAM_DEPTH;

  logic [ADDR_W-1:0] io_off, sram_off;

  assign io_off     = addr_i - ADDR_W'(IO_BASE);
  assign sram_off   = addr_i - ADDR_W'(SRAM_BASE);
  assign rf_idx_o   = addr_i[RF_AW-1:0];
  assign io_idx_o   = io_off[IO_AW-1:0];
  assign sram_idx_o = sram_off[SRAM_AW-1:0];

  always_comb begin
    if (addr_i < ADDR_W'(IO_BASE))        tgt_o = TGT_RF;
    else if (addr_i < ADDR_W'(SRAM_BASE)) tgt_o = TGT_IO;
    else if (addr_i < ADDR_W'(EXT_BASE))  tgt_o = TGT_SRAM;
    else                                  tgt_o = TGT_EXT;
  end
endmodule

// File: rtl/dsr_ext_ctrl.sv
module dsr_ext_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (!busy_q) begin
      busy_q <= start_i && !ready_i;
      if (start_i) begin
        addr_q  <= addr_i;
        we_q    <= we_i;
        wdata_q <= wdata_i;
      end
    end else if (ready_i) begin
      busy_q <= 1'b0;
    end
  end

  // first cycle forwards the live request, later cycles the frozen copy
  assign busy_o  = busy_q;
  assign req_o   = busy_q | start_i;
  assign addr_o  = busy_q ? addr_q  : addr_i;
  assign we_o    = busy_q ? we_q    : we_i;
  assign wdata_o = busy_q ? wdata_q : wdata_i;

  assert_busy_reset_R10: assert property (@(posedge clk_i)
    $fell(rst_ni) |-> !busy_q);
endmodule

// File: rtl/dsr_rd_ret.sv
module dsr_rd_ret #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= fire_i;
      if (fire_i) rdata_o <= data_i;
    end
  end

  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !$past(fire_i) |-> 1'b0);
endmodule

// File: rtl/dspace_router.sv
module dspace_router
  import dsr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RF_DEPTH   = 32,
  parameter int IO_DEPTH   = 64,
  parameter int SRAM_DEPTH = 1024
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ds_req_i,
  input  logic                          ds_we_i,
  input  logic [ADDR_W-1:0]             ds_addr_i,
  input  logic [DATA_W-1:0]             ds_wdata_i,
  output logic                          ds_ready_o,
  output logic [DATA_W-1:0]             ds_rdata_o,
  output logic                          ds_rvalid_o,
  input  logic                          io_req_i,
  input  logic                          io_we_i,
  input  logic [$clog2(IO_DEPTH)-1:0]   io_addr_i,
  input  logic [DATA_W-1:0]             io_wdata_i,
  output logic                          io_ready_o,
  output logic [DATA_W-1:0]             io_rdata_o,
  output logic                          io_rvalid_o,
  output logic                          rf_req_o,
  output logic                          rf_we_o,
  output logic [$clog2(RF_DEPTH)-1:0]   rf_addr_o,
  output logic [DATA_W-1:0]             rf_wdata_o,
  input  logic [DATA_W-1:0]             rf_rdata_i,
  output logic                          iot_req_o,
  output logic                          iot_we_o,
  output logic [$clog2(IO_DEPTH)-1:0]   iot_addr_o,
  output logic [DATA_W-1:0]             iot_wdata_o,
  input  logic [DATA_W-1:0]             iot_rdata_i,
  output logic                          sram_req_o,
  output logic                          sram_we_o,
  output logic [$clog2(SRAM_DEPTH)-1:0] sram_addr_o,
  output logic [DATA_W-1:0]             sram_wdata_o,
  input  logic [DATA_W-1:0]             sram_rdata_i,
  output logic                          ext_req_o,
  output logic                          ext_we_o,
  output logic [ADDR_W-1:0]             ext_addr_o,
  output logic [DATA_W-1:0]             ext_wdata_o,
  input  logic [DATA_W-1:0]             ext_rdata_i,
  input  logic                          ext_ready_i
);
  localparam int IO_AW     = $clog2(IO_DEPTH);
  localparam int IO_BASE   = RF_DEPTH;
  localparam int SRAM_BASE = IO_BASE + IO_DEPTH;
  localparam int EXT_BASE  = SRAM_BASE + SRAM_DEPTH;

  tgt_e                          tgt;
  logic [$clog2(RF_DEPTH)-1:0]   rf_idx;
  logic [IO_AW-1:0]              io_idx;
  logic [$clog2(SRAM_DEPTH)-1:0] sram_idx;
  logic                          ext_busy, ext_start;
  logic                          ds_go_int, ds_io;
  logic                          ds_we_eff;
  logic [DATA_W-1:0]             ds_rd_mux;

  dsr_decode #(
    .ADDR_W(ADDR_W), .RF_DEPTH(RF_DEPTH), .IO_DEPTH(IO_DEPTH), .SRAM_DEPTH(SRAM_DEPTH)
  ) i_decode (
    .addr_i    (ds_addr_i),
    .tgt_o     (tgt),
    .rf_idx_o  (rf_idx),
    .io_idx_o  (io_idx),
    .sram_idx_o(sram_idx)
  );

  // direct I/O wins; the data-space port waits while the external bus is busy
  assign ds_go_int = ds_req_i && !io_req_i && !ext_busy && (tgt != TGT_EXT);
  assign ext_start = ds_req_i && !io_req_i && !ext_busy && (tgt == TGT_EXT);
  assign ds_io     = ds_go_int && (tgt == TGT_IO);

  dsr_ext_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ext_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ext_start),
    .ready_i(ext_ready_i),
    .addr_i (ds_addr_i),
    .we_i   (ds_we_i),
    .wdata_i(ds_wdata_i),
    .busy_o (ext_busy),
    .req_o  (ext_req_o),
    .addr_o (ext_addr_o),
    .we_o   (ext_we_o),
    .wdata_o(ext_wdata_o)
  );

  assign rf_req_o     = ds_go_int && (tgt == TGT_RF);
  assign rf_we_o      = ds_we_i;
  assign rf_addr_o    = rf_idx;
  assign rf_wdata_o   = ds_wdata_i;

  assign sram_req_o   = ds_go_int && (tgt == TGT_SRAM);
  assign sram_we_o    = ds_we_i;
  assign sram_addr_o  = sram_idx;
  assign sram_wdata_o = ds_wdata_i;

  assign iot_req_o    = io_req_i || ds_io;
  assign iot_we_o     = io_req_i ? io_we_i    : ds_we_i;
  assign iot_addr_o   = io_req_i ? io_addr_i  : io_idx;
  assign iot_wdata_o  = io_req_i ? io_wdata_i : ds_wdata_i;

  assign io_ready_o   = io_req_i;
  assign ds_ready_o   = ds_go_int || (ext_req_o && ext_ready_i);
  assign ds_we_eff    = ext_req_o ? ext_we_o : ds_we_i;

  always_comb begin
    if (ext_req_o) ds_rd_mux = ext_rdata_i;
    else begin
      unique case (tgt)
        TGT_RF:   ds_rd_mux = rf_rdata_i;
        TGT_IO:   ds_rd_mux = iot_rdata_i;
        TGT_SRAM: ds_rd_mux = sram_rdata_i;
        default:  ds_rd_mux = ext_rdata_i;
      endcase
    end
  end

  dsr_rd_ret #(.DATA_W(DATA_W)) i_ds_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (ds_ready_o && !ds_we_eff),
    .data_i  (ds_rd_mux),
    .rdata_o (ds_rdata_o),
    .rvalid_o(ds_rvalid_o)
  );

  dsr_rd_ret #(.DATA_W(DATA_W)) i_io_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (io_req_i && !io_we_i),
    .data_i  (iot_rdata_i),
    .rdata_o (io_rdata_o),
    .rvalid_o(io_rvalid_o)
  );

  assert_rf_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_req_o |-> ds_addr_i < ADDR_W'(IO_BASE) && !sram_req_o && !ext_req_o);

  assert_io_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iot_req_o && !io_req_i |-> ds_addr_i >= ADDR_W'(IO_BASE) && ds_addr_i < ADDR_W'(SRAM_BASE));

  assert_sram_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_req_o |-> ds_addr_i >= ADDR_W'(SRAM_BASE) && ds_addr_i < ADDR_W'(EXT_BASE)
                 && ADDR_W'(sram_addr_o) + ADDR_W'(SRAM_BASE) == ds_addr_i);

  assert_ext_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> ext_addr_o >= ADDR_W'(EXT_BASE));

  assert_io_direct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_i |-> iot_req_o && io_ready_o && iot_addr_o == io_addr_i);

  assert_io_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_i && !ext_req_o |-> !ds_ready_o);

  assert_ext_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o && !ext_ready_i |=> ext_req_o && $stable(ext_addr_o)
                                  && $stable(ext_we_o) && $stable(ext_wdata_o));

  assert_rvalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_rvalid_o |-> $past(ds_ready_o));
endmodule

// File: tb/test_dspace_router.sv
module test_dspace_router;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ds_req_i = 0, ds_we_i = 0;
  logic [15:0] ds_addr_i = '0;
  logic [7:0]  ds_wdata_i = '0;
  logic        ds_ready_o, ds_rvalid_o;
  logic [7:0]  ds_rdata_o;
  logic        io_req_i = 0, io_we_i = 0;
  logic [5:0]  io_addr_i = '0;
  logic [7:0]  io_wdata_i = '0;
  logic        io_ready_o, io_rvalid_o;
  logic [7:0]  io_rdata_o;
  logic        rf_req_o, rf_we_o, iot_req_o, iot_we_o, sram_req_o, sram_we_o;
  logic        ext_req_o, ext_we_o, ext_ready_i = 0;
  logic [4:0]  rf_addr_o;
  logic [5:0]  iot_addr_o;
  logic [9:0]  sram_addr_o;
  logic [15:0] ext_addr_o;
  logic [7:0]  rf_wdata_o, iot_wdata_o, sram_wdata_o, ext_wdata_o;
  logic [7:0]  rf_rdata_i, iot_rdata_i, sram_rdata_i, ext_rdata_i;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // target models: data is a fixed function of the received index
  assign rf_rdata_i   = 8'hA0 ^ {3'b000, rf_addr_o};
  assign iot_rdata_i  = 8'h5A ^ {2'b00, iot_addr_o};
  assign sram_rdata_i = sram_addr_o[7:0] ^ {sram_addr_o[9:8], 6'h15};
  assign ext_rdata_i  = ext_addr_o[7:0] + ext_addr_o[15:8];

  dspace_router i_dspace_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .ds_req_i(ds_req_i), .ds_we_i(ds_we_i), .ds_addr_i(ds_addr_i), .ds_wdata_i(ds_wdata_i),
    .ds_ready_o(ds_ready_o), .ds_rdata_o(ds_rdata_o), .ds_rvalid_o(ds_rvalid_o),
    .io_req_i(io_req_i), .io_we_i(io_we_i), .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i),
    .io_ready_o(io_ready_o), .io_rdata_o(io_rdata_o), .io_rvalid_o(io_rvalid_o),
    .rf_req_o(rf_req_o), .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o),
    .rf_wdata_o(rf_wdata_o), .rf_rdata_i(rf_rdata_i),
    .iot_req_o(iot_req_o), .iot_we_o(iot_we_o), .iot_addr_o(iot_addr_o),
    .iot_wdata_o(iot_wdata_o), .iot_rdata_i(iot_rdata_i),
    .sram_req_o(sram_req_o), .sram_we_o(sram_we_o), .sram_addr_o(sram_addr_o),
    .sram_wdata_o(sram_wdata_o), .sram_rdata_i(sram_rdata_i),
    .ext_req_o(ext_req_o), .ext_we_o(ext_we_o), .ext_addr_o(ext_addr_o),
    .ext_wdata_o(ext_wdata_o), .ext_rdata_i(ext_rdata_i), .ext_ready_i(ext_ready_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int region(input int a);
    if (a < 'h20) return 0;
    if (a < 'h60) return 1;
    if (a < 'h460) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] exp_data(input int a);
    logic [9:0]  si;
    logic [15:0] ea;
    si = 10'(a - 'h60);
    ea = 16'(a);
    case (region(a))
      0: return 8'hA0 ^ 8'(a);
      1: return 8'h5A ^ 8'(a - 'h20);
      2: return si[7:0] ^ {si[9:8], 6'h15};
      default: return ea[7:0] + ea[15:8];
    endcase
  endfunction

  function automatic string rtag(input int r);
    case (r)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic ds_acc(input int a, input bit we, input logic [7:0] wd, input int waits);
    int r, n;
    logic [3:0] vec, evec;
    string tg;
    r = region(a);
    tg = rtag(r);
    n = 0;
    @(negedge clk);
    ds_req_i = 1; ds_addr_i = 16'(a); ds_we_i = we; ds_wdata_i = wd;
    ext_ready_i = (r == 3) && (waits == 0);
    #1;
    while (!ds_ready_o && n <= waits + 2) begin
      if (r == 3)  // R7 hold while waiting
        chk(ext_req_o && ext_addr_o == 16'(a) && ext_we_o == we && ext_wdata_o == wd,
            "R7", int'(ext_addr_o), a);
      @(negedge clk);
      n++;
      ext_ready_i = (r == 3) && (n >= waits);
      #1;
    end
    chk(ds_ready_o && n == ((r == 3) ? waits : 0), (r == 3) ? "R7" : tg, n, (r == 3) ? waits : 0);
    vec  = {rf_req_o, iot_req_o, sram_req_o, ext_req_o};
    evec = 4'b1000 >> r;
    chk(vec == evec, tg, int'(vec), int'(evec));
    case (r)
      0: chk(rf_addr_o == 5'(a), "R1", int'(rf_addr_o), a);
      1: chk(iot_addr_o == 6'(a - 'h20), "R2", int'(iot_addr_o), a - 'h20);
      2: chk(sram_addr_o == 10'(a - 'h60), "R3", int'(sram_addr_o), a - 'h60);
      default: chk(ext_addr_o == 16'(a), "R4", int'(ext_addr_o), a);
    endcase
    if (we) begin
      case (r)
        0: chk(rf_we_o && rf_wdata_o == wd, "R11", int'(rf_wdata_o), int'(wd));
        1: chk(iot_we_o && iot_wdata_o == wd, "R11", int'(iot_wdata_o), int'(wd));
        2: chk(sram_we_o && sram_wdata_o == wd, "R11", int'(sram_wdata_o), int'(wd));
        default: chk(ext_we_o && ext_wdata_o == wd, "R11", int'(ext_wdata_o), int'(wd));
      endcase
    end
    @(negedge clk);
    ds_req_i = 0; ext_ready_i = 0;
    #1;
    if (we) chk(!ds_rvalid_o, "R9", int'(ds_rvalid_o), 0);
    else chk(ds_rvalid_o && ds_rdata_o == exp_data(a), "R9", int'(ds_rdata_o), int'(exp_data(a)));
  endtask

  task automatic io_acc(input int k, input bit we, input logic [7:0] wd);
    @(negedge clk);
    io_req_i = 1; io_addr_i = 6'(k); io_we_i = we; io_wdata_i = wd;
    #1;
    chk(io_ready_o && iot_req_o && iot_addr_o == 6'(k) && iot_we_o == we, "R5", int'(iot_addr_o), k);
    if (we) chk(iot_wdata_o == wd, "R11", int'(iot_wdata_o), int'(wd));
    @(negedge clk);
    io_req_i = 0;
    #1;
    if (we) chk(!io_rvalid_o, "R9", int'(io_rvalid_o), 0);
    else chk(io_rvalid_o && io_rdata_o == exp_data(k + 'h20), "R5",
             int'(io_rdata_o), int'(exp_data(k + 'h20)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!ds_rvalid_o && !io_rvalid_o && !ext_req_o, "R10", int'(ds_rvalid_o), 0);
    @(negedge clk);
    rst_ni = 1;
    #1;
    chk(!ds_rvalid_o && !io_rvalid_o && !ext_req_o && !ds_ready_o, "R10", int'(ext_req_o), 0);

    // R1 R2 R3 R4: every address up to just past the SRAM top, read
    for (int a = 0; a < 'h480; a++) ds_acc(a, 0, 8'h00, 0);
    // R4 R7: external region stride with varying wait states
    for (int a = 'h460; a <= 'hFFFF; a += 'h1F3) ds_acc(a, 0, 8'h00, a % 4);
    ds_acc('hFFFF, 0, 8'h00, 3);
    // R11: stores into each region, including an external one with waits
    for (int i = 0; i < 8; i++) begin
      ds_acc(i * 5, 1, 8'(8'h11 * i + 3), 0);
      ds_acc('h20 + i * 7, 1, 8'(8'hC3 ^ i), 0);
      ds_acc('h60 + i * 127, 1, 8'(8'h5E + i), 0);
      ds_acc('h460 + i * 'h1F00, 1, 8'(8'h80 | i), i % 3);
    end
    // R5: every direct I/O number, read and write
    for (int k = 0; k < 64; k++) io_acc(k, 0, 8'h00);
    for (int k = 0; k < 64; k += 9) io_acc(k, 1, 8'(k * 3));

    // R6: simultaneous direct I/O and data-space I/O read
    @(negedge clk);
    io_req_i = 1; io_addr_i = 6'd5; io_we_i = 0;
    ds_req_i = 1; ds_addr_i = 16'h0030; ds_we_i = 0;
    #1;
    chk(io_ready_o && !ds_ready_o && iot_addr_o == 6'd5, "R6", int'(ds_ready_o), 0);
    @(negedge clk);
    io_req_i = 0;
    #1;
    chk(io_rvalid_o && io_rdata_o == exp_data('h25), "R6", int'(io_rdata_o), int'(exp_data('h25)));
    chk(ds_ready_o && iot_addr_o == 6'h10, "R6", int'(iot_addr_o), 'h10);
    @(negedge clk);
    ds_req_i = 0;
    #1;
    chk(ds_rvalid_o && ds_rdata_o == exp_data('h30), "R6", int'(ds_rdata_o), int'(exp_data('h30)));

    // R6: simultaneous direct I/O and external request: external starts a cycle late
    @(negedge clk);
    io_req_i = 1; io_addr_i = 6'd40; io_we_i = 0;
    ds_req_i = 1; ds_addr_i = 16'h9000; ds_we_i = 0; ext_ready_i = 1;
    #1;
    chk(!ext_req_o && !ds_ready_o, "R6", int'(ext_req_o), 0);
    @(negedge clk);
    io_req_i = 0;
    #1;
    chk(ext_req_o && ds_ready_o && ext_addr_o == 16'h9000, "R6", int'(ext_addr_o), 'h9000);
    @(negedge clk);
    ds_req_i = 0; ext_ready_i = 0;
    #1;
    chk(ds_rvalid_o && ds_rdata_o == exp_data('h9000), "R6", int'(ds_rdata_o), int'(exp_data('h9000)));

    // R8: direct I/O during external wait
    @(negedge clk);
    ds_req_i = 1; ds_addr_i = 16'h8001; ds_we_i = 0; ext_ready_i = 0;
    @(negedge clk);
    io_req_i = 1; io_addr_i = 6'd9; io_we_i = 0;
    #1;
    chk(io_ready_o && iot_addr_o == 6'd9 && ext_req_o && !ds_ready_o && ext_addr_o == 16'h8001,
        "R8", int'(ext_addr_o), 'h8001);
    @(negedge clk);
    io_req_i = 0; ext_ready_i = 1;
    #1;
    chk(io_rvalid_o && io_rdata_o == exp_data('h29), "R8", int'(io_rdata_o), int'(exp_data('h29)));
    chk(ds_ready_o, "R7", int'(ds_ready_o), 1);
    @(negedge clk);
    ds_req_i = 0; ext_ready_i = 0;
    #1;
    chk(ds_rvalid_o && ds_rdata_o == exp_data('h8001), "R8", int'(ds_rdata_o), int'(exp_data('h8001)));
    @(negedge clk);
    #1;
    chk(!ds_rvalid_o && !ext_req_o, "R9", int'(ds_rvalid_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule